// File: doc/BRIEF.md
# Extended-Precision Compare and Classify Unit

This unit produces the four condition-code bits (C3, C2, C1, C0) of a stack-based floating-point coprocessor. An operation request has four kinds. Compare orders the stack-top operand against a source operand. Test is the same ordering with positive zero in place of the source. Examine reports the class and sign of the stack top. Remainder status packs the outcome of one partial-remainder step. The arithmetic, the register stack and exception handling are outside the block. The block only turns operands and status into the condition-code encoding.

Operands use an 80-bit extended format. Bit 79 is the sign, bits 78:64 hold a 15-bit biased exponent and bits 63:0 hold the significand. Significand bit 63 is an explicit integer bit. The condition code is registered and is written one cycle after a request, with a one-cycle valid strobe. Bits that an operation does not define keep their previous values.

Top module: `fpcc_unit`

## Requirements
- R1: Compare (`req_op`=00) writes {C3,C2,C0} as 000 when the stack top is greater than the source, 001 when it is less and 100 when they are equal. The ordering is signed, using the magnitude key {exponent, significand}, and +0 equals -0.
- R2: A compare or test is unordered and writes {C3,C2,C0}=111 when either operand is a NaN (exponent all ones, significand bits 62:0 nonzero) or when `st_empty` is 1.
- R3: Compare and test never change C1.
- R4: Test (`req_op`=01) ignores `src_val` and orders the stack top against +0 with the encodings of R1 and R2.
- R5: Examine (`req_op`=10) writes C3 C2 C1 C0 = c3 c2 s c0, where s is the sign. {c3,c2,c0} is 100 for zero, 110 for exponent zero with a nonzero significand, 000 for a nonzero exponent with integer bit 0, 010 for a normal value, 011 for infinity (exponent all ones, bits 62:0 zero) and 001 for a NaN.
- R6: Examine of an empty stack top writes C3=1, C2=0, C1=sign, C0=1.
- R7: Remainder (`req_op`=11) with `rem_done`=1 writes C2=0, C1=`rem_quot`[0], C3=`rem_quot`[1] and C0=`rem_quot`[2].
- R8: Remainder with `rem_done`=0 writes C2=1. The other bits are undefined.
- R9: `cc` and `cc_vld` change one clock after a cycle with `req_vld`=1. `cc_vld` is high for exactly that one cycle, and `cc` holds its value when there is no request.
- R10: While reset is applied, `cc` is 0000 and `cc_vld` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_vld | input | 1 | Operation request |
| req_op | input | 2 | 00 compare, 01 test, 10 examine, 11 remainder |
| st_val | input | 80 | Stack-top operand |
| src_val | input | 80 | Source operand for compare |
| st_empty | input | 1 | Stack top is tagged empty |
| rem_done | input | 1 | Remainder reduction complete |
| rem_quot | input | 3 | Low three quotient bits |
| cc | output | 4 | Condition code {C3,C2,C1,C0} |
| cc_vld | output | 1 | One-cycle strobe on update |

## Verification
A misclassified operand shows as a wrong examine code one cycle after the request. A wrong ordering decision shows as a wrong compare code at the same point. A C1 that is corrupted by a compare only shows at the compare, unless a later examine or remainder overwrites it, so the bench tracks the expected C1 across sequences of operations. The bench sweeps compare over every pair from a table of operands, each paired with an independently assigned rank, with and without the empty tag. It also covers test, examine and every quotient pattern, so a wrong mapping appears at the first affected request.

// File: rtl/fpcc_pkg.sv
package fpcc_pkg;

  typedef enum logic [1:0] {
    OP_COMPARE   = 2'b00,
    OP_TEST      = 2'b01,
    OP_EXAMINE   = 2'b10,
    OP_REMAINDER = 2'b11
  } cc_op_e;

  typedef enum logic [2:0] {
    CL_ZERO,
    CL_DENORM,
    CL_UNNORM,
    CL_NORM,
    CL_INF,
    CL_NAN
  } fp_class_e;

  typedef enum logic [1:0] {
    ORD_GT,
    ORD_LT,
    ORD_EQ,
    ORD_UN
  } fp_order_e;

endpackage

// File: rtl/fpcc_rst_sync.sv
module fpcc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/fpcc_classify.sv
module fpcc_classify
  import fpcc_pkg::*;
#(
  parameter int EXP_W = 15,
  parameter int SIG_W = 64
) (
  input  logic [EXP_W+SIG_W:0]   val,
  output fp_class_e              cls,
  output logic                   sign,
  output logic [EXP_W+SIG_W-1:0] key
);
  localparam int FRAC_W = SIG_W - 1;

  logic [EXP_W-1:0]  expo;
  logic [SIG_W-1:0]  sig;
  logic              int_bit;
  logic [FRAC_W-1:0] frac;

  assign sign    = val[EXP_W+SIG_W];
  assign expo    = val[EXP_W+SIG_W-1:SIG_W];
  assign sig     = val[SIG_W-1:0];
  assign int_bit = sig[SIG_W-1];
  assign frac    = sig[FRAC_W-1:0];
  assign key     = {expo, sig};

  always_comb begin
    if (&expo) begin
      cls = (frac == '0) ? CL_INF : CL_NAN;
    end else if (expo == '0) begin
      cls = (sig == '0) ? CL_ZERO : CL_DENORM;
    end else begin
      cls = int_bit ? CL_NORM : CL_UNNORM;
    end
  end
endmodule

// File: rtl/fpcc_order.sv
module fpcc_order
  import fpcc_pkg::*;
#(
  parameter int KEY_W = 79
) (
  input  fp_class_e        cls_a,
  input  fp_class_e        cls_b,
  input  logic             sign_a,
  input  logic             sign_b,
  input  logic [KEY_W-1:0] key_a,
  input  logic [KEY_W-1:0] key_b,
  input  logic             empty_a,
  output fp_order_e        order
);
  logic mag_gt;
  logic mag_eq;

  assign mag_gt = key_a > key_b;
  assign mag_eq = key_a == key_b;

  always_comb begin
    if (empty_a || cls_a == CL_NAN || cls_b == CL_NAN) begin
      order = ORD_UN;
    end else if (cls_a == CL_ZERO && cls_b == CL_ZERO) begin
      order = ORD_EQ;
    end else if (sign_a != sign_b) begin
      order = sign_a ? ORD_LT : ORD_GT;
    end else if (mag_eq) begin
      order = ORD_EQ;
    end else if (mag_gt ^ sign_a) begin
      order = ORD_GT;
    end else begin
      order = ORD_LT;
    end
  end
endmodule

// File: rtl/fpcc_unit.sv
module fpcc_unit
  import fpcc_pkg::*;
#(
  parameter int EXP_W       = 15,
  parameter int SIG_W       = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_vld,
  input  logic [1:0]           req_op,
  input  logic [EXP_W+SIG_W:0] st_val,
  input  logic [EXP_W+SIG_W:0] src_val,
  input  logic                 st_empty,
  input  logic                 rem_done,
  input  logic [2:0]           rem_quot,
  output logic [3:0]           cc,
  output logic                 cc_vld
);
  localparam int VAL_W = EXP_W + SIG_W + 1;
  localparam int KEY_W = EXP_W + SIG_W;
  localparam int N_OPS = 2;

  logic rst_sync_n;
  fpcc_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_sync_n)
  );

  cc_op_e op;
  assign op = cc_op_e'(req_op);

  logic [VAL_W-1:0] opnd   [N_OPS];
  fp_class_e        cls    [N_OPS];
  logic             sgn    [N_OPS];
  logic [KEY_W-1:0] key    [N_OPS];

  assign opnd[0] = st_val;
  assign opnd[1] = (op == OP_TEST) ? '0 : src_val;

  for (genvar g = 0; g < N_OPS; g++) begin : g_cls
    fpcc_classify #(.EXP_W(EXP_W), .SIG_W(SIG_W)) u_cls (
      .val  (opnd[g]),
      .cls  (cls[g]),
      .sign (sgn[g]),
      .key  (key[g])
    );
  end

  fp_order_e order;
  fpcc_order #(.KEY_W(KEY_W)) u_ord (
    .cls_a   (cls[0]),
    .cls_b   (cls[1]),
    .sign_a  (sgn[0]),
    .sign_b  (sgn[1]),
    .key_a   (key[0]),
    .key_b   (key[1]),
    .empty_a (st_empty),
    .order   (order)
  );

  logic [3:0] cc_q, cc_d;
  logic       vld_q, vld_d;
  logic       cc_en;
  logic [2:0] ord_bits;
  logic [2:0] cls_bits;

  always_comb begin
    unique case (order)
      ORD_GT:  ord_bits = 3'b000;
      ORD_LT:  ord_bits = 3'b001;
      ORD_EQ:  ord_bits = 3'b100;
      default: ord_bits = 3'b111;
    endcase
  end

  always_comb begin
    unique case (cls[0])
      CL_ZERO:   cls_bits = 3'b100;
      CL_DENORM: cls_bits = 3'b110;
      CL_UNNORM: cls_bits = 3'b000;
      CL_NORM:   cls_bits = 3'b010;
      CL_INF:    cls_bits = 3'b011;
      default:   cls_bits = 3'b001;
    endcase
  end

  always_comb begin
    cc_en = req_vld;
    vld_d = req_vld;
    cc_d  = cc_q;
    unique case (op)
      OP_COMPARE, OP_TEST: begin
        cc_d = {ord_bits[2], ord_bits[1], cc_q[1], ord_bits[0]};
      end
      OP_EXAMINE: begin
        if (st_empty) begin
          cc_d = {1'b1, 1'b0, sgn[0], 1'b1};
        end else begin
          cc_d = {cls_bits[2], cls_bits[1], sgn[0], cls_bits[0]};
        end
      end
      default: begin
        if (rem_done) begin
          cc_d = {rem_quot[1], 1'b0, rem_quot[0], rem_quot[2]};
        end else begin
          cc_d = {cc_q[3], 1'b1, cc_q[1], cc_q[0]};
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      cc_q  <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
      if (cc_en) begin
        cc_q <= cc_d;
      end
    end
  end

  assign cc     = cc_q;
  assign cc_vld = vld_q;
endmodule

// File: rtl/fpcc_unit_chk.sv
module fpcc_unit_chk
  import fpcc_pkg::*;
(
  input logic       clk,
  input logic       rst_ns,
  input logic       req_vld,
  input logic [1:0] req_op,
  input logic       st_empty,
  input logic       rem_done,
  input logic [2:0] rem_quot,
  input logic [3:0] cc,
  input logic       cc_vld
);
  logic is_cmp;
  assign is_cmp = req_vld && (req_op == OP_COMPARE || req_op == OP_TEST);

  assert_strobe_R9: assert property (@(posedge clk) disable iff (!rst_ns)
    req_vld |=> cc_vld);
  assert_strobe_low_R9: assert property (@(posedge clk) disable iff (!rst_ns)
    !req_vld |=> !cc_vld);
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_ns)
    !req_vld |=> $stable(cc));
  assert_c1_kept_R3: assert property (@(posedge clk) disable iff (!rst_ns)
    is_cmp |=> $stable(cc[1]));
  assert_unordered_empty_R2: assert property (@(posedge clk) disable iff (!rst_ns)
    (is_cmp && st_empty) |=> (cc[3] && cc[2] && cc[0]));
  assert_exam_empty_R6: assert property (@(posedge clk) disable iff (!rst_ns)
    (req_vld && req_op == OP_EXAMINE && st_empty) |=> (cc[3] && !cc[2] && cc[0]));
  assert_rem_done_R7: assert property (@(posedge clk) disable iff (!rst_ns)
    (req_vld && req_op == OP_REMAINDER && rem_done) |=>
      (cc == {$past(rem_quot[1]), 1'b0, $past(rem_quot[0]), $past(rem_quot[2])}));
  assert_rem_partial_R8: assert property (@(posedge clk) disable iff (!rst_ns)
    (req_vld && req_op == OP_REMAINDER && !rem_done) |=> cc[2]);
endmodule

bind fpcc_unit fpcc_unit_chk u_chk (
  .clk      (clk),
  .rst_ns   (rst_sync_n),
  .req_vld  (req_vld),
  .req_op   (req_op),
  .st_empty (st_empty),
  .rem_done (rem_done),
  .rem_quot (rem_quot),
  .cc       (cc),
  .cc_vld   (cc_vld)
);

// File: tb/fpcc_unit_tb.sv
module fpcc_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 14;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_vld;
  logic [1:0]  req_op;
  logic [79:0] st_val, src_val;
  logic        st_empty, rem_done;
  logic [2:0]  rem_quot;
  logic [3:0]  cc;
  logic        cc_vld;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fpcc_unit u_dut (
    .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_op(req_op),
    .st_val(st_val), .src_val(src_val), .st_empty(st_empty),
    .rem_done(rem_done), .rem_quot(rem_quot), .cc(cc), .cc_vld(cc_vld)
  );

  // operand table: value, independent rank, expected {C3,C2,C0} class, NaN flag
  logic [79:0] tv   [NV];
  int          rank [NV];
  logic [2:0]  tcls [NV];
  bit          tnan [NV];

  logic [3:0] cc_m;   // expected code
  logic [3:0] km;     // bits of cc_m that are defined

  function automatic logic [79:0] mk(input logic s, input logic [14:0] e, input logic [63:0] m);
    return {s, e, m};
  endfunction

  task automatic set_tv(input int i, input logic [79:0] v, input int r, input logic [2:0] c, input bit n);
    tv[i] = v; rank[i] = r; tcls[i] = c; tnan[i] = n;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp, input logic [31:0] mask);
    checks++;
    if ((act & mask) !== (exp & mask)) begin
      errors++;
      $display("FAIL %s: actual %h expected %h (mask %h)", req, act, exp, mask);
    end
  endtask

  function automatic logic [2:0] ord_code(input int ra, input int rb);
    if (ra > rb) return 3'b000;
    if (ra < rb) return 3'b001;
    return 3'b100;
  endfunction

  // issue one request at the current negedge; check after the next posedge
  task automatic issue(input logic [1:0] op, input logic [79:0] a, input logic [79:0] b,
                       input logic e, input logic d, input logic [2:0] q);
    req_vld = 1'b1; req_op = op; st_val = a; src_val = b;
    st_empty = e; rem_done = d; rem_quot = q;
    @(negedge clk);
    req_vld = 1'b0;
    chk("R9 strobe", {31'd0, cc_vld}, 32'd1, 32'd1);
  endtask

  task automatic do_cmp(input int i, input int j, input logic e, input bit test);
    logic [2:0] x;
    logic [79:0] src;
    src = test ? tv[13] : tv[j];
    if (e || tnan[i] || (!test && tnan[j])) x = 3'b111;
    else x = ord_code(rank[i], test ? 0 : rank[j]);
    issue(test ? 2'b01 : 2'b00, tv[i], src, e, 1'b0, 3'd0);
    cc_m = {x[2], x[1], cc_m[1], x[0]};
    if (e || tnan[i] || (!test && tnan[j]))
      chk(test ? "R2 test unordered" : "R2 unordered", {28'd0, cc}, {28'd0, cc_m}, {28'd0, km});
    else if (test)
      chk("R4 test vs +0", {28'd0, cc}, {28'd0, cc_m}, {28'd0, km});
    else
      chk("R1 ordering", {28'd0, cc}, {28'd0, cc_m}, {28'd0, km});
    chk("R3 C1 kept", {31'd0, cc[1]}, {31'd0, cc_m[1]}, {31'd0, km[1]});
  endtask

  task automatic do_exam(input int i, input logic e);
    issue(2'b10, tv[i], tv[0], e, 1'b0, 3'd0);
    if (e) cc_m = {1'b1, 1'b0, tv[i][79], 1'b1};
    else   cc_m = {tcls[i][2], tcls[i][1], tv[i][79], tcls[i][0]};
    km = 4'hF;
    chk(e ? "R6 examine empty" : "R5 examine class", {28'd0, cc}, {28'd0, cc_m}, 32'hF);
  endtask

  task automatic do_rem(input logic d, input logic [2:0] q);
    issue(2'b11, tv[0], tv[0], 1'b0, d, q);
    if (d) begin
      cc_m = {q[1], 1'b0, q[0], q[2]};
      km = 4'hF;
      chk("R7 remainder done", {28'd0, cc}, {28'd0, cc_m}, 32'hF);
    end else begin
      cc_m[2] = 1'b1;
      km = 4'b0100;
      chk("R8 remainder partial", {28'd0, cc}, {28'd0, cc_m}, {28'd0, km});
    end
  endtask

  task automatic idle_chk();
    @(negedge clk);
    chk("R9 strobe low", {31'd0, cc_vld}, 32'd0, 32'd1);
    chk("R9 hold", {28'd0, cc}, {28'd0, cc_m}, {28'd0, km});
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    set_tv(0,  mk(0, 15'h0000, 64'h0), 0, 3'b100, 0);                       // +0
    set_tv(1,  mk(1, 15'h0000, 64'h0), 0, 3'b100, 0);                       // -0
    set_tv(2,  mk(0, 15'h0000, 64'h1), 1, 3'b110, 0);                       // +tiny
    set_tv(3,  mk(1, 15'h0000, 64'h1), -1, 3'b110, 0);                      // -tiny
    set_tv(4,  mk(0, 15'h3FFF, 64'h8000_0000_0000_0000), 6, 3'b010, 0);     // +1
    set_tv(5,  mk(1, 15'h3FFF, 64'h8000_0000_0000_0000), -6, 3'b010, 0);    // -1
    set_tv(6,  mk(0, 15'h3FFF, 64'hC000_0000_0000_0000), 7, 3'b010, 0);     // +1.5
    set_tv(7,  mk(0, 15'h4000, 64'h4000_0000_0000_0000), 8, 3'b000, 0);     // unnormal
    set_tv(8,  mk(0, 15'h4000, 64'h8000_0000_0000_0000), 9, 3'b010, 0);     // +2
    set_tv(9,  mk(1, 15'h4000, 64'h8000_0000_0000_0000), -9, 3'b010, 0);    // -2
    set_tv(10, mk(0, 15'h7FFF, 64'h8000_0000_0000_0000), 20, 3'b011, 0);    // +inf
    set_tv(11, mk(1, 15'h7FFF, 64'h8000_0000_0000_0000), -20, 3'b011, 0);   // -inf
    set_tv(12, mk(0, 15'h7FFF, 64'hC000_0000_0000_0000), 0, 3'b001, 1);     // NaN
    set_tv(13, mk(1, 15'h7FFF, 64'hC000_0000_0000_0001), 0, 3'b001, 1);     // -NaN (also test garbage source)

    rst_n = 1'b0; req_vld = 1'b0; req_op = 2'b00; st_val = '0; src_val = '0;
    st_empty = 1'b0; rem_done = 1'b0; rem_quot = 3'd0;
    cc_m = 4'h0; km = 4'hF;
    repeat (3) @(negedge clk);
    chk("R10 reset cc", {28'd0, cc}, 32'd0, 32'hF);
    chk("R10 reset vld", {31'd0, cc_vld}, 32'd0, 32'd1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R10 after release", {28'd0, cc}, 32'd0, 32'hF);

    // set C1 to 1 then compare: C1 must survive
    do_exam(5, 1'b0);
    for (int i = 0; i < NV; i++)
      for (int j = 0; j < NV; j++)
        for (int e = 0; e < 2; e++)
          do_cmp(i, j, e[0], 1'b0);
    idle_chk();
    do_exam(0, 1'b0);
    for (int i = 0; i < NV; i++)
      for (int e = 0; e < 2; e++)
        do_cmp(i, 0, e[0], 1'b1);
    idle_chk();
    for (int i = 0; i < NV; i++)
      for (int e = 0; e < 2; e++)
        do_exam(i, e[0]);
    for (int q = 0; q < 8; q++) begin
      do_rem(1'b1, q[2:0]);
      idle_chk();
      do_rem(1'b0, q[2:0]);
    end
    do_exam(9, 1'b0);
    do_cmp(4, 8, 1'b0, 1'b0);
    idle_chk();
    idle_chk();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule